// File: doc/BRIEF.md
# LCD Scan Timing Generator

This block drives a parallel RGB LCD panel from a fast system clock. It divides the system clock down to a pixel rate and issues a one-cycle pixel-clock enable at that rate. It walks a horizontal and a vertical position counter, and from programmable timing values it produces the pixel clock pin, horizontal and vertical sync, a data-enable window and the colour buses.

A pixel source outside the block watches the requested coordinate and returns the colour for it. The colour is captured on the next pixel-clock enable and reaches the pins two pixel clocks after its coordinate was requested. The same delay applies to sync and data enable, so all panel signals stay aligned.

An optional colour-spread mode staggers the upper bits of red and blue around green, which spreads out the switching of the buses. A free-running cycle tally and a frame tally are also provided. The timing values arrive as plain input ports. They are captured at frame start, so the host may change them at any time.

Top module: `lcd_scan_timer`

## Requirements
- R1: With a nonzero divisor D, `pclk_en` is high for one system clock in every D system clocks. With D = 1 it is high on every cycle.
- R2: With a divisor of 0 all output is suspended. `pclk_en`, `pclk`, `de`, `pix_req`, `pix_x`, `pix_y` and the colour buses are 0, `hsync` and `vsync` are high, and `frame_count` holds its value. Scanning restarts at position (0,0) once the divisor is nonzero again.
- R3: For D ≥ 2, `pclk` equals `cfg_pol` in the cycle where `pclk_en` is high and equals its inverse in the following cycle. Output updates therefore coincide with the rising `pclk` edge when `cfg_pol` is 0 and with the falling edge when it is 1.
- R4: The horizontal position steps 0..HCYCLE-1 on each `pclk_en`, and the line number steps when the horizontal position wraps. Pins reflect position (h,v) two `pclk_en` strobes after the counters held it. `de` is high for HOFFSET ≤ h < HOFFSET+HSIZE within a visible row.
- R5: `hsync` is low for positions h with HSYNC_FALL ≤ h < HSYNC_RISE and high otherwise.
- R6: A frame is VCYCLE lines long. Rows VOFFSET ≤ v < VOFFSET+VSIZE are visible, and `vsync` is low for VSYNC_FALL ≤ v < VSYNC_RISE.
- R7: While the current position is visible, `pix_req` is high, `pix_x` = h−HOFFSET and `pix_y` = v−VOFFSET. Otherwise `pix_req` is low and both coordinates are 0.
- R8: With colour spread off, `lcd_r`, `lcd_g` and `lcd_b` all carry the same pixel's colour, and all three are 0 while `de` is low.
- R9: With colour spread on, bits [7:2] of `lcd_r` carry the next pixel's red and bits [7:2] of `lcd_b` carry the previous pixel's blue. Bits [1:0] stay aligned with green.
- R10: All timing values and the spread mode are captured only at reset, while the divisor is 0, and on the `pclk_en` that wraps from the last position of a frame to (0,0). A change made mid-frame has no effect until the next frame.
- R11: `frame_count` is 0 after reset and increments by one on each frame wrap.
- R12: `clk_count` is 0 after reset and increments by one on every system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| cfg_div | input | 8 | pixel clock divisor, 0 suspends |
| cfg_pol | input | 1 | pixel clock polarity |
| cfg_spread | input | 1 | colour-spread enable |
| cfg_hcycle | input | 10 | pixel clocks per line |
| cfg_hsize | input | 10 | visible pixels per line |
| cfg_hoffset | input | 10 | first visible pixel position |
| cfg_hsync_fall | input | 10 | position where hsync falls |
| cfg_hsync_rise | input | 10 | position where hsync rises |
| cfg_vcycle | input | 10 | lines per frame |
| cfg_vsize | input | 10 | visible lines per frame |
| cfg_voffset | input | 10 | first visible line |
| cfg_vsync_fall | input | 10 | line where vsync falls |
| cfg_vsync_rise | input | 10 | line where vsync rises |
| pix_r | input | 8 | red from pixel source |
| pix_g | input | 8 | green from pixel source |
| pix_b | input | 8 | blue from pixel source |
| pclk | output | 1 | panel pixel clock |
| pclk_en | output | 1 | one-cycle pixel rate strobe |
| hsync | output | 1 | horizontal sync, active low |
| vsync | output | 1 | vertical sync, active low |
| de | output | 1 | data enable |
| lcd_r | output | 8 | red to panel |
| lcd_g | output | 8 | green to panel |
| lcd_b | output | 8 | blue to panel |
| pix_req | output | 1 | requested coordinate is visible |
| pix_x | output | 10 | requested column |
| pix_y | output | 10 | requested row |
| frame_count | output | 32 | frames since reset |
| clk_count | output | 32 | system clocks since reset |

## Verification
The assertions assume that HCYCLE and VCYCLE are at least 2, that each sync fall position is below its rise position, and that the visible windows fit inside the cycle lengths. The position-range and wrap checks rely on these. Every configuration the stimulus applies respects them. The divisor is only ever changed by passing through a suspended phase, so each divisor run starts from a cleared phase counter. Timing values and the spread bit are changed a few cycles after a frame wrap, which leaves the following frame to show whether the change was held back.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    localparam int POS_W     = 10;
    localparam int DIV_W     = 8;
    localparam int COL_W     = 8;
    localparam int SPREAD_LO = 2;
    localparam int TALLY_W   = 32;

    typedef logic [POS_W-1:0] pos_t;
    typedef logic [COL_W-1:0] col_t;

    typedef struct packed {
        pos_t cycle;
        pos_t size;
        pos_t offset;
        pos_t sync_fall;
        pos_t sync_rise;
    } axis_cfg_t;

    typedef struct packed {
        axis_cfg_t h;
        axis_cfg_t v;
        logic      spread;
    } scan_cfg_t;

    typedef struct packed {
        logic hsync;
        logic vsync;
        logic de;
        logic spread;
        col_t r;
        col_t g;
        col_t b;
    } lane_t;

    localparam lane_t LANE_IDLE = '{hsync: 1'b1, vsync: 1'b1, de: 1'b0, spread: 1'b0,
                                    r: '0, g: '0, b: '0};

    // start <= p < start + len, evaluated one bit wider to avoid wrap
    function automatic logic in_span(pos_t p, pos_t start, pos_t len);
        logic [POS_W:0] pe;
        logic [POS_W:0] se;
        logic [POS_W:0] ee;
        pe = {1'b0, p};
        se = {1'b0, start};
        ee = se + {1'b0, len};
        return (pe >= se) && (pe < ee);
    endfunction

    function automatic logic sync_active(pos_t p, pos_t fall, pos_t rise);
        return (p >= fall) && (p < rise);
    endfunction

endpackage

// File: rtl/lcd_pclk_gen.sv
module lcd_pclk_gen
    import lcd_scan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    input  logic             pol,
    output logic             running,
    output logic             tick,
    output logic             pclk
);

    logic [DIV_W-1:0] phase;
    logic [DIV_W-1:0] half;

    assign running = (div != '0);
    assign tick    = running && (phase >= div - 1'b1);
    assign half    = (div >> 1) + DIV_W'(div[0]);
    assign pclk    = running ? ((phase < half) ^ pol) : 1'b0;

    always_ff @(posedge clk) begin
        if (rst || !running) begin
            phase <= '0;
        end else if (tick) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // a strobe is never followed by another unless the divisor is one
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
        tick |=> (!tick || div == DIV_W'(1)));

endmodule

// File: rtl/lcd_scan_cnt.sv
module lcd_scan_cnt
    import lcd_scan_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               running,
    input  logic               tick,
    input  scan_cfg_t          cfg_in,
    output scan_cfg_t          cfg_q,
    output pos_t               h_pos,
    output pos_t               v_pos,
    output logic               frame_wrap,
    output logic [TALLY_W-1:0] frames
);

    logic h_last;
    logic v_last;

    assign h_last     = (h_pos == cfg_q.h.cycle - 1'b1);
    assign v_last     = (v_pos == cfg_q.v.cycle - 1'b1);
    assign frame_wrap = tick && h_last && v_last;

    always_ff @(posedge clk) begin
        if (rst || !running) begin
            h_pos <= '0;
            v_pos <= '0;
            cfg_q <= cfg_in;
        end else if (tick) begin
            if (h_last) begin
                h_pos <= '0;
                if (v_last) begin
                    v_pos <= '0;
                    cfg_q <= cfg_in;
                end else begin
                    v_pos <= v_pos + 1'b1;
                end
            end else begin
                h_pos <= h_pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frames <= '0;
        end else if (frame_wrap) begin
            frames <= frames + 1'b1;
        end
    end

    p_hpos_range_r4: assert property (@(posedge clk) disable iff (rst)
        running |-> (h_pos < cfg_q.h.cycle));

    p_wrap_origin_r4: assert property (@(posedge clk) disable iff (rst)
        frame_wrap |=> (h_pos == '0 && v_pos == '0));

    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (running && !frame_wrap) |=> $stable(cfg_q));

    p_frame_step_r11: assert property (@(posedge clk) disable iff (rst)
        frame_wrap |=> (frames == $past(frames) + 1'b1));

endmodule

// File: rtl/lcd_pix_pipe.sv
module lcd_pix_pipe
    import lcd_scan_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  running,
    input  logic  tick,
    input  lane_t fetch,
    output lane_t wire_o
);

    localparam int HI = COL_W - 1;

    lane_t stage1;
    lane_t stage2;
    col_t  blue_late;

    always_ff @(posedge clk) begin
        if (rst || !running) begin
            stage1    <= LANE_IDLE;
            stage2    <= LANE_IDLE;
            blue_late <= '0;
        end else if (tick) begin
            stage1    <= fetch;
            stage2    <= stage1;
            blue_late <= stage2.b;
        end
    end

    // green, syncs and enable come from stage2; the upper red bits lead by
    // one pixel and the upper blue bits trail by one pixel in spread mode
    always_comb begin
        wire_o = stage2;
        if (stage2.spread) begin
            wire_o.r[HI:SPREAD_LO] = stage1.r[HI:SPREAD_LO];
            wire_o.b[HI:SPREAD_LO] = blue_late[HI:SPREAD_LO];
        end
    end

    p_blue_trail_r9: assert property (@(posedge clk) disable iff (rst)
        (running && tick) |=>
            (!stage2.spread || wire_o.b[HI:SPREAD_LO] == $past(stage2.b[HI:SPREAD_LO])));

endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
    import lcd_scan_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic               cfg_pol,
    input  logic               cfg_spread,
    input  logic [POS_W-1:0]   cfg_hcycle,
    input  logic [POS_W-1:0]   cfg_hsize,
    input  logic [POS_W-1:0]   cfg_hoffset,
    input  logic [POS_W-1:0]   cfg_hsync_fall,
    input  logic [POS_W-1:0]   cfg_hsync_rise,
    input  logic [POS_W-1:0]   cfg_vcycle,
    input  logic [POS_W-1:0]   cfg_vsize,
    input  logic [POS_W-1:0]   cfg_voffset,
    input  logic [POS_W-1:0]   cfg_vsync_fall,
    input  logic [POS_W-1:0]   cfg_vsync_rise,
    input  logic [COL_W-1:0]   pix_r,
    input  logic [COL_W-1:0]   pix_g,
    input  logic [COL_W-1:0]   pix_b,
    output logic               pclk,
    output logic               pclk_en,
    output logic               hsync,
    output logic               vsync,
    output logic               de,
    output logic [COL_W-1:0]   lcd_r,
    output logic [COL_W-1:0]   lcd_g,
    output logic [COL_W-1:0]   lcd_b,
    output logic               pix_req,
    output logic [POS_W-1:0]   pix_x,
    output logic [POS_W-1:0]   pix_y,
    output logic [TALLY_W-1:0] frame_count,
    output logic [TALLY_W-1:0] clk_count
);

    logic      running;
    logic      tick;
    logic      frame_wrap;
    scan_cfg_t cfg_in;
    scan_cfg_t cfg_q;
    pos_t      h_pos;
    pos_t      v_pos;
    logic      h_vis;
    logic      v_vis;
    logic      vis;
    lane_t     fetch;
    lane_t     lane_out;

    always_comb begin
        cfg_in.h.cycle     = cfg_hcycle;
        cfg_in.h.size      = cfg_hsize;
        cfg_in.h.offset    = cfg_hoffset;
        cfg_in.h.sync_fall = cfg_hsync_fall;
        cfg_in.h.sync_rise = cfg_hsync_rise;
        cfg_in.v.cycle     = cfg_vcycle;
        cfg_in.v.size      = cfg_vsize;
        cfg_in.v.offset    = cfg_voffset;
        cfg_in.v.sync_fall = cfg_vsync_fall;
        cfg_in.v.sync_rise = cfg_vsync_rise;
        cfg_in.spread      = cfg_spread;
    end

    lcd_pclk_gen u_pclk (
        .clk     (clk),
        .rst     (rst),
        .div     (cfg_div),
        .pol     (cfg_pol),
        .running (running),
        .tick    (tick),
        .pclk    (pclk)
    );

    lcd_scan_cnt u_cnt (
        .clk        (clk),
        .rst        (rst),
        .running    (running),
        .tick       (tick),
        .cfg_in     (cfg_in),
        .cfg_q      (cfg_q),
        .h_pos      (h_pos),
        .v_pos      (v_pos),
        .frame_wrap (frame_wrap),
        .frames     (frame_count)
    );

    always_comb begin
        h_vis        = in_span(h_pos, cfg_q.h.offset, cfg_q.h.size);
        v_vis        = in_span(v_pos, cfg_q.v.offset, cfg_q.v.size);
        vis          = h_vis && v_vis;
        fetch.hsync  = !sync_active(h_pos, cfg_q.h.sync_fall, cfg_q.h.sync_rise);
        fetch.vsync  = !sync_active(v_pos, cfg_q.v.sync_fall, cfg_q.v.sync_rise);
        fetch.de     = vis;
        fetch.spread = cfg_q.spread;
        fetch.r      = vis ? pix_r : '0;
        fetch.g      = vis ? pix_g : '0;
        fetch.b      = vis ? pix_b : '0;
    end

    lcd_pix_pipe u_pipe (
        .clk     (clk),
        .rst     (rst),
        .running (running),
        .tick    (tick),
        .fetch   (fetch),
        .wire_o  (lane_out)
    );

    assign pclk_en = tick;
    assign hsync   = lane_out.hsync;
    assign vsync   = lane_out.vsync;
    assign de      = lane_out.de;
    assign lcd_r   = lane_out.r;
    assign lcd_g   = lane_out.g;
    assign lcd_b   = lane_out.b;
    assign pix_req = running && vis;
    assign pix_x   = pix_req ? (h_pos - cfg_q.h.offset) : '0;
    assign pix_y   = pix_req ? (v_pos - cfg_q.v.offset) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_count <= '0;
        end else begin
            clk_count <= clk_count + 1'b1;
        end
    end

    p_suspend_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_div == '0) |=> (hsync && vsync && !de && lcd_g == '0 && lcd_r == '0));

    p_blank_green_r8: assert property (@(posedge clk) disable iff (rst)
        !de |-> (lcd_g == '0));

    p_tally_step_r12: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (clk_count == $past(clk_count) + 1'b1));

endmodule

// File: tb/lcd_scan_timer_tb.sv
module lcd_scan_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  div = 8'd3;
    logic        pol = 1'b0;
    logic        spread = 1'b0;
    logic [9:0]  hcyc = 10'd12, hsz = 10'd5, hoff = 10'd4, hfall = 10'd1, hrise = 10'd3;
    logic [9:0]  vcyc = 10'd7,  vsz = 10'd3, voff = 10'd2, vfall = 10'd0, vrise = 10'd1;
    logic [7:0]  pix_r, pix_g, pix_b;
    logic        pclk, pclk_en, hsync, vsync, de, pix_req;
    logic [7:0]  lcd_r, lcd_g, lcd_b;
    logic [9:0]  pix_x, pix_y;
    logic [31:0] frame_count, clk_count;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [7:0] red_of(int x, int y);
        return 8'((x * 8 + 5 + y * 64) & 255);
    endfunction
    function automatic logic [7:0] grn_of(int x, int y);
        return 8'((y * 16 + x + 1) & 255);
    endfunction
    function automatic logic [7:0] blu_of(int x, int y);
        return 8'((((x ^ 10) * 16) + y * 4 + 2) & 255);
    endfunction

    assign pix_r = red_of(int'(pix_x), int'(pix_y));
    assign pix_g = grn_of(int'(pix_x), int'(pix_y));
    assign pix_b = blu_of(int'(pix_x), int'(pix_y));

    lcd_scan_timer u_dut (
        .clk(clk), .rst(rst), .cfg_div(div), .cfg_pol(pol), .cfg_spread(spread),
        .cfg_hcycle(hcyc), .cfg_hsize(hsz), .cfg_hoffset(hoff),
        .cfg_hsync_fall(hfall), .cfg_hsync_rise(hrise),
        .cfg_vcycle(vcyc), .cfg_vsize(vsz), .cfg_voffset(voff),
        .cfg_vsync_fall(vfall), .cfg_vsync_rise(vrise),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .pclk(pclk), .pclk_en(pclk_en), .hsync(hsync), .vsync(vsync), .de(de),
        .lcd_r(lcd_r), .lcd_g(lcd_g), .lcd_b(lcd_b),
        .pix_req(pix_req), .pix_x(pix_x), .pix_y(pix_y),
        .frame_count(frame_count), .clk_count(clk_count)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- reference model, evaluated at falling edges ----------------
    typedef struct packed {
        logic hs; logic vs; logic de; logic sp;
        logic [7:0] r; logic [7:0] g; logic [7:0] b;
    } exp_t;
    localparam exp_t E_IDLE = '{hs: 1'b1, vs: 1'b1, de: 1'b0, sp: 1'b0, r: 8'd0, g: 8'd0, b: 8'd0};

    int mh, mv, mframes, gap;
    int m_hc, m_hs, m_ho, m_hf, m_hr, m_vc, m_vs, m_vo, m_vf, m_vr;
    bit m_sp, gap_ok, anti;
    exp_t e1, e2;
    logic [7:0] eb;

    task automatic latch_cfg();
        m_hc = int'(hcyc); m_hs = int'(hsz); m_ho = int'(hoff); m_hf = int'(hfall); m_hr = int'(hrise);
        m_vc = int'(vcyc); m_vs = int'(vsz); m_vo = int'(voff); m_vf = int'(vfall); m_vr = int'(vrise);
        m_sp = spread;
    endtask

    task automatic model_restart();
        mh = 0; mv = 0; e1 = E_IDLE; e2 = E_IDLE; eb = 8'd0;
        latch_cfg(); gap = 0; gap_ok = 1'b1; anti = 1'b0;
    endtask

    function automatic bit m_vis(int h, int v);
        return (h >= m_ho) && (h < m_ho + m_hs) && (v >= m_vo) && (v < m_vo + m_vs);
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            model_restart();
            mframes = 0;
        end else begin
            exp_t o;
            bit   vis;
            o = e2;
            if (e2.sp) begin
                o.r[7:2] = e1.r[7:2];
                o.b[7:2] = eb[7:2];
            end
            chk(hsync == o.hs, "R5 hsync", hsync, o.hs);
            chk(vsync == o.vs, "R6 vsync", vsync, o.vs);
            chk(de == o.de, "R4 de", de, o.de);
            chk(lcd_g == o.g, "R8 green", lcd_g, o.g);
            chk(lcd_r == o.r, o.sp ? "R9 red" : "R8 red", lcd_r, o.r);
            chk(lcd_b == o.b, o.sp ? "R9 blue" : "R8 blue", lcd_b, o.b);
            chk(frame_count == 32'(mframes), "R11 frames", frame_count, mframes);
            vis = (div != 8'd0) && m_vis(mh, mv);
            chk(pix_req == vis, "R7 pix_req", pix_req, vis);
            chk(pix_x == (vis ? 10'(mh - m_ho) : 10'd0), "R7 pix_x", pix_x, vis ? mh - m_ho : 0);
            chk(pix_y == (vis ? 10'(mv - m_vo) : 10'd0), "R7 pix_y", pix_y, vis ? mv - m_vo : 0);
            if (anti && div >= 8'd2)
                chk(pclk == !pol, "R3 pclk after strobe", pclk, !pol);
            anti = 1'b0;
            if (div == 8'd0) begin
                chk(!pclk_en && !pclk, "R2 clock idle", {pclk_en, pclk}, 0);
                model_restart();
            end else if (pclk_en) begin
                if (gap_ok)
                    chk(gap + 1 == int'(div), "R1 strobe spacing", gap + 1, div);
                if (div >= 8'd2) begin
                    chk(pclk == pol, "R3 pclk at strobe", pclk, pol);
                    anti = 1'b1;
                end
                gap = 0;
                eb = e2.b;
                e2 = e1;
                e1.hs = !(mh >= m_hf && mh < m_hr);
                e1.vs = !(mv >= m_vf && mv < m_vr);
                e1.de = m_vis(mh, mv);
                e1.sp = m_sp;
                e1.r  = e1.de ? red_of(mh - m_ho, mv - m_vo) : 8'd0;
                e1.g  = e1.de ? grn_of(mh - m_ho, mv - m_vo) : 8'd0;
                e1.b  = e1.de ? blu_of(mh - m_ho, mv - m_vo) : 8'd0;
                if (mh == m_hc - 1) begin
                    mh = 0;
                    if (mv == m_vc - 1) begin
                        mv = 0;
                        mframes++;
                        latch_cfg();
                    end else begin
                        mv++;
                    end
                end else begin
                    mh++;
                end
            end else begin
                gap++;
            end
        end
    end

    // ---------------- scenario tasks ----------------
    task automatic next_frame();
        logic [31:0] f0;
        @(negedge clk);
        f0 = frame_count;
        while (frame_count == f0) @(negedge clk);
    endtask

    task automatic count_de_frame(output int n);
        logic [31:0] f0;
        n = 0;
        f0 = frame_count;
        while (frame_count == f0) begin
            if (de) n++;
            @(negedge clk);
        end
    endtask

    task automatic change_div(input logic [7:0] d);
        @(posedge clk); #1 div = 8'd0;
        repeat (3) @(posedge clk);
        #1 div = d;
    endtask

    task automatic t_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(hsync && vsync && !de, "R2 reset syncs idle", {hsync, vsync, de}, 6);
        chk(lcd_r == 0 && lcd_g == 0 && lcd_b == 0, "R8 reset colours zero", {lcd_r, lcd_g, lcd_b}, 0);
        chk(frame_count == 0, "R11 reset frame count", frame_count, 0);
        chk(clk_count == 0, "R12 reset clock tally", clk_count, 0);
        @(posedge clk); #1 rst = 1'b0;
    endtask

    task automatic t_basic();
        int n;
        logic [31:0] f0;
        next_frame();
        count_de_frame(n);
        chk(n == 5 * 3 * 3, "R4 enabled cycles per frame", n, 45);
        f0 = frame_count;
        repeat (12 * 7 * 3) @(negedge clk);
        chk(frame_count == f0 + 1, "R11 one frame per period", frame_count, f0 + 1);
    endtask

    task automatic t_tally();
        logic [31:0] c0;
        @(negedge clk);
        c0 = clk_count;
        repeat (50) @(negedge clk);
        chk(clk_count == c0 + 50, "R12 tally over 50 clocks", clk_count, c0 + 50);
    endtask

    task automatic t_polarity();
        @(posedge clk); #1 pol = 1'b1;
        next_frame();
        next_frame();
        @(posedge clk); #1 pol = 1'b0;
    endtask

    task automatic t_divisor(input logic [7:0] d);
        int n;
        change_div(d);
        n = 0;
        repeat (100) begin
            @(negedge clk);
            if (pclk_en) n++;
        end
        chk(n == 100 / int'(d), "R1 strobes per 100 clocks", n, 100 / int'(d));
        next_frame();
    endtask

    task automatic t_suspend();
        logic [31:0] f0;
        bit idle;
        @(posedge clk); #1 div = 8'd0;
        @(negedge clk);
        f0 = frame_count;
        idle = 1'b1;
        repeat (16) begin
            @(negedge clk);
            if (!(hsync && vsync && !de && !pclk && !pclk_en && !pix_req &&
                  lcd_r == 0 && lcd_g == 0 && lcd_b == 0)) idle = 1'b0;
        end
        chk(idle, "R2 outputs idle while suspended", idle, 1);
        chk(frame_count == f0, "R2 frame count held", frame_count, f0);
        @(posedge clk); #1 div = 8'd3;
        next_frame();
    endtask

    task automatic t_midframe();
        int n;
        next_frame();
        repeat (5) @(posedge clk);
        #1 hsz = 10'd3;
        @(negedge clk);
        count_de_frame(n);
        chk(n == 45, "R10 old width kept for rest of frame", n, 45);
        @(negedge clk);
        count_de_frame(n);
        chk(n == 3 * 3 * 3, "R10 new width from next frame", n, 27);
        @(posedge clk); #1 hsz = 10'd5;
        next_frame();
    endtask

    task automatic t_spread();
        next_frame();
        repeat (5) @(posedge clk);
        #1 spread = 1'b1;
        next_frame();
        next_frame();
        @(posedge clk); #1 spread = 1'b0;
        next_frame();
        next_frame();
    endtask

    initial begin
        t_reset();
        t_basic();
        t_tally();
        t_polarity();
        t_divisor(8'd1);
        t_divisor(8'd5);
        t_divisor(8'd3);
        t_suspend();
        t_midframe();
        t_spread();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule